// File: doc/BRIEF.md
# UART Receiver Host Register Port

This block is the processor-facing side of a UART receiver. A processor reads one of two registers through it: the last received character or an 8-bit status word. A read is decoded from a group of chip-select lines that must all be high, a read/write line that is high for a read, and a register-select line. The bus is modelled as an 8-bit output with a separate output-enable, which stands for a three-state driver. When no selected read is in progress, the data output is held at zero.

The block holds the data-available flag. A one-cycle pulse from the receiver sets the flag when a character lands in the holding register. The processor clears it with a latch strobe that arrives during a selected character read. The strobe and the external-status pin are asynchronous, so both pass through a synchronizer before they are used. The pins the block drives are:

- an active-low data-available/interrupt pin;
- an active-low pin that combines the parity and overrun errors;
- a framing-error pin.

Top module: `uart_host_if`

## Requirements
- R1: `bus_oe` is high exactly when every `cs_in` bit is high and `rd_wr` is high.
- R2: While `bus_oe` is high, `bus_out` carries the status word when `reg_sel` is 1 and `rx_char` when `reg_sel` is 0. While `bus_oe` is low, `bus_out` is 0.
- R3: The status word bits, from bit 7 down to bit 0, are: `tx_hold_empty`, `tx_shift_empty`, `periph_irq`, external status, `rx_fe`, `rx_pe`, `rx_oe`, data-available.
- R4: A one-cycle `rx_ready` pulse sets data-available at the next clock edge. While data-available is set, `avail_irq_n` is low.
- R5: Data-available clears on the rising edge of `latch_stb` after it passes through the synchronizer, provided a selected character read (`reg_sel` = 0) is in progress in that cycle. The clear takes effect SYNC_STAGES+1 clock edges after the strobe rises.
- R6: A strobe has no effect on data-available during a status read, a write, or while any chip select is low.
- R7: `err_n` equals NOT(`rx_pe` OR `rx_oe`), and `frame_err` equals `rx_fe`.
- R8: The external-status bit is 1 when `ext_stat_n` is low, and it follows the pin after SYNC_STAGES clock edges.
- R9: After reset, data-available is 0, `avail_irq_n` is 1 and the external-status bit is 0.
- R10: When `rx_ready` arrives in the same cycle as a clearing strobe edge, data-available stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_in | input | CS_COUNT | Chip selects; all must be high to select the block |
| rd_wr | input | 1 | High for a read cycle |
| reg_sel | input | 1 | 1 selects the status word, 0 selects the character |
| latch_stb | input | 1 | Asynchronous latch strobe from the processor |
| rx_ready | input | 1 | Pulse: a new character is in the holding register |
| rx_char | input | 8 | Holding-register contents |
| rx_pe | input | 1 | Parity error flag from the receiver |
| rx_fe | input | 1 | Framing error flag from the receiver |
| rx_oe | input | 1 | Overrun error flag from the receiver |
| tx_hold_empty | input | 1 | Transmit holding register empty |
| tx_shift_empty | input | 1 | Transmit shift register empty |
| periph_irq | input | 1 | Peripheral status interrupt |
| ext_stat_n | input | 1 | External status pin, active low |
| bus_out | output | 8 | Read data |
| bus_oe | output | 1 | Bus driver enable |
| avail_irq_n | output | 1 | Inverted data-available / interrupt pin |
| err_n | output | 1 | Active-low parity-or-overrun pin |
| frame_err | output | 1 | Framing-error pin |

## Verification
The decode is swept over all 32 combinations of chip selects, read/write and register-select. Each combination is tried with all 64 patterns of the six directly mapped status inputs and with both levels of the external pin. This sweep separates a wrong enable term, a swapped register choice and a misplaced status bit.

The data-available flag is then run through four sequences:
- set and clear;
- strobes during a status read, a write and a deselected cycle;
- a strobe edge that meets a new character in the same cycle;
- the delay of the strobe and of the external pin through the synchronizer.

These sequences separate a clear that is not qualified from a correct one, and a clear that wins over a new character from one that yields to it.

// File: rtl/uart_hif_pkg.sv
package uart_hif_pkg;
  localparam int unsigned BYTE_W = 8;

  // Field order fixes the bit position in the status word (bit 7 first).
  typedef struct packed {
    logic thr_empty;
    logic tsr_empty;
    logic periph;
    logic ext;
    logic frame;
    logic parity;
    logic overrun;
    logic avail;
  } hif_status_t;
endpackage

// File: rtl/uart_hif_sync.sv
module uart_hif_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q, chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= {STAGES{RST_VAL}};
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/uart_hif_avail.sv
module uart_hif_avail (
  input  logic clk,
  input  logic rst_n,
  input  logic stb_sync,
  input  logic data_rd,
  input  logic rx_ready,
  output logic avail
);
  logic stb_prev_q, avail_q, avail_d, clr;

  assign clr = stb_sync & ~stb_prev_q & data_rd;

  always_comb begin
    avail_d = avail_q;
    if (clr)      avail_d = 1'b0;
    if (rx_ready) avail_d = 1'b1;   // a new character wins over a clear
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_prev_q <= 1'b0;
      avail_q    <= 1'b0;
    end else begin
      stb_prev_q <= stb_sync;
      avail_q    <= avail_d;
    end
  end

  assign avail = avail_q;
endmodule

// File: rtl/uart_hif_bus.sv
module uart_hif_bus
  import uart_hif_pkg::*;
#(
  parameter int unsigned CS_COUNT = 3
) (
  input  logic [CS_COUNT-1:0] cs_in,
  input  logic                rd_wr,
  input  logic                reg_sel,
  input  logic [BYTE_W-1:0]   rx_char,
  input  hif_status_t         status,
  output logic                data_rd,
  output logic [BYTE_W-1:0]   bus_out,
  output logic                bus_oe
);
  logic rd_en;

  always_comb begin
    rd_en   = (&cs_in) & rd_wr;
    data_rd = rd_en & ~reg_sel;
    bus_out = '0;
    if (rd_en) bus_out = reg_sel ? BYTE_W'(status) : rx_char;
  end

  assign bus_oe = rd_en;
endmodule

// File: rtl/uart_host_if.sv
module uart_host_if
  import uart_hif_pkg::*;
#(
  parameter int unsigned CS_COUNT    = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CS_COUNT-1:0] cs_in,
  input  logic                rd_wr,
  input  logic                reg_sel,
  input  logic                latch_stb,
  input  logic                rx_ready,
  input  logic [7:0]          rx_char,
  input  logic                rx_pe,
  input  logic                rx_fe,
  input  logic                rx_oe,
  input  logic                tx_hold_empty,
  input  logic                tx_shift_empty,
  input  logic                periph_irq,
  input  logic                ext_stat_n,
  output logic [7:0]          bus_out,
  output logic                bus_oe,
  output logic                avail_irq_n,
  output logic                err_n,
  output logic                frame_err
);
  logic        stb_sync, ext_n_sync, data_rd, avail;
  hif_status_t status;

  uart_hif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_stb_sync (
    .clk(clk), .rst_n(rst_n), .d(latch_stb), .q(stb_sync));

  uart_hif_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_stat_n), .q(ext_n_sync));

  uart_hif_avail u_avail (
    .clk(clk), .rst_n(rst_n), .stb_sync(stb_sync), .data_rd(data_rd),
    .rx_ready(rx_ready), .avail(avail));

  always_comb begin
    status.thr_empty = tx_hold_empty;
    status.tsr_empty = tx_shift_empty;
    status.periph    = periph_irq;
    status.ext       = ~ext_n_sync;
    status.frame     = rx_fe;
    status.parity    = rx_pe;
    status.overrun   = rx_oe;
    status.avail     = avail;
  end

  uart_hif_bus #(.CS_COUNT(CS_COUNT)) u_bus (
    .cs_in(cs_in), .rd_wr(rd_wr), .reg_sel(reg_sel), .rx_char(rx_char),
    .status(status), .data_rd(data_rd), .bus_out(bus_out), .bus_oe(bus_oe));

  assign avail_irq_n = ~avail;
  assign err_n       = ~(rx_pe | rx_oe);
  assign frame_err   = rx_fe;
endmodule

// File: rtl/uart_host_if_chk.sv
module uart_host_if_chk #(
  parameter int unsigned CS_COUNT = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [CS_COUNT-1:0] cs_in,
  input logic                rd_wr,
  input logic                reg_sel,
  input logic                rx_ready,
  input logic                tx_hold_empty,
  input logic [7:0]          bus_out,
  input logic                bus_oe,
  input logic                avail_irq_n
);
  a_r1_enable_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> ((&cs_in) && rd_wr));

  a_r2_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_oe |-> (bus_out == 8'h00));

  a_r3_avail_bit0: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && reg_sel) |-> (bus_out[0] == !avail_irq_n));

  a_r3_thre_bit7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_oe && reg_sel) |-> (bus_out[7] == tx_hold_empty));

  a_r4_ready_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !avail_irq_n);

  a_r6_clear_only_on_data_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(avail_irq_n) |-> $past((&cs_in) && rd_wr && !reg_sel));
endmodule

bind uart_host_if uart_host_if_chk #(.CS_COUNT(CS_COUNT)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .rd_wr(rd_wr), .reg_sel(reg_sel),
  .rx_ready(rx_ready), .tx_hold_empty(tx_hold_empty), .bus_out(bus_out),
  .bus_oe(bus_oe), .avail_irq_n(avail_irq_n));

// File: tb/uart_host_if_test.sv
`timescale 1ns/1ps
module uart_host_if_test;
  logic clk = 1'b0;
  logic rst_n;
  logic [2:0] cs_in;
  logic rd_wr, reg_sel, latch_stb, rx_ready;
  logic [7:0] rx_char;
  logic rx_pe, rx_fe, rx_oe, tx_hold_empty, tx_shift_empty, periph_irq, ext_stat_n;
  logic [7:0] bus_out;
  logic bus_oe, avail_irq_n, err_n, frame_err;

  int vectors = 0;
  int errors  = 0;
  bit done    = 0;

  always #2 clk = ~clk;

  uart_host_if #(.CS_COUNT(3), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .cs_in(cs_in), .rd_wr(rd_wr), .reg_sel(reg_sel),
    .latch_stb(latch_stb), .rx_ready(rx_ready), .rx_char(rx_char),
    .rx_pe(rx_pe), .rx_fe(rx_fe), .rx_oe(rx_oe), .tx_hold_empty(tx_hold_empty),
    .tx_shift_empty(tx_shift_empty), .periph_irq(periph_irq),
    .ext_stat_n(ext_stat_n), .bus_out(bus_out), .bus_oe(bus_oe),
    .avail_irq_n(avail_irq_n), .err_n(err_n), .frame_err(frame_err));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Read the status word; bit 0 is data-available (R3).
  task automatic rd_status(output logic [7:0] v);
    cs_in = 3'b111; rd_wr = 1'b1; reg_sel = 1'b1;
    #1 v = bus_out;
  endtask

  task automatic pulse_ready();
    rx_ready = 1'b1; cyc(1); rx_ready = 1'b0;
  endtask

  // Raise the strobe with the given bus setup, hold it 4 cycles, then drop it.
  task automatic strobe(input logic [2:0] cs, input logic rw, input logic rs);
    cs_in = cs; rd_wr = rw; reg_sel = rs;
    latch_stb = 1'b1; cyc(4);
    latch_stb = 1'b0; cyc(3);
  endtask

  initial begin
    #(4.0 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] s;
    rst_n = 1'b0; cs_in = '0; rd_wr = 0; reg_sel = 0; latch_stb = 0; rx_ready = 0;
    rx_char = 8'h00; rx_pe = 0; rx_fe = 0; rx_oe = 0; tx_hold_empty = 0;
    tx_shift_empty = 0; periph_irq = 0; ext_stat_n = 1'b1;
    cyc(3); rst_n = 1'b1; cyc(2);

    // R9: reset state
    chk("R9 avail_irq_n", {7'd0, avail_irq_n}, 8'h01);
    rd_status(s);
    chk("R9 status", s, 8'h00);

    // R1 R2 R3 R7 R8: sweep decode and status inputs, data-available is 0
    for (int e = 0; e < 2; e++) begin
      ext_stat_n = e[0];
      cyc(3);
      for (int v = 0; v < 64; v++) begin
        {tx_hold_empty, tx_shift_empty, periph_irq, rx_fe, rx_pe, rx_oe} = v[5:0];
        rx_char = 8'(v * 37 + 5);
        #1;
        chk("R7 err_n", {7'd0, err_n}, {7'd0, ~(v[1] | v[0])});
        chk("R7 frame_err", {7'd0, frame_err}, {7'd0, v[2]});
        for (int c = 0; c < 32; c++) begin
          logic en;
          logic [7:0] exp;
          {cs_in, rd_wr, reg_sel} = c[4:0];
          #1;
          en  = (c[4:2] == 3'b111) && c[1];
          exp = !en ? 8'h00 :
                c[0] ? {v[5], v[4], v[3], ~e[0], v[2], v[1], v[0], 1'b0} :
                       8'(v * 37 + 5);
          chk("R1 bus_oe", {7'd0, bus_oe}, {7'd0, en});
          chk("R2 R3 bus_out", bus_out, exp);
        end
      end
    end
    {tx_hold_empty, tx_shift_empty, periph_irq, rx_fe, rx_pe, rx_oe} = '0;
    cyc(1);

    // R8: synchronizer delay of the external pin
    ext_stat_n = 1'b0; cyc(1);
    rd_status(s); chk("R8 not yet after 1 edge", {7'd0, s[4]}, 8'h00);
    cyc(1);
    rd_status(s); chk("R8 after 2 edges", {7'd0, s[4]}, 8'h01);
    ext_stat_n = 1'b1; cyc(3);

    // R4: ready pulse sets data-available
    cs_in = 3'b000; rd_wr = 0;
    pulse_ready();
    chk("R4 avail_irq_n low", {7'd0, avail_irq_n}, 8'h00);
    rd_status(s); chk("R4 status bit0", s, 8'h01);

    // R6: strobes that must not clear
    strobe(3'b111, 1'b1, 1'b1);
    chk("R6 status read strobe", {7'd0, avail_irq_n}, 8'h00);
    strobe(3'b111, 1'b0, 1'b0);
    chk("R6 write strobe", {7'd0, avail_irq_n}, 8'h00);
    strobe(3'b011, 1'b1, 1'b0);
    chk("R6 deselected strobe", {7'd0, avail_irq_n}, 8'h00);

    // R5: timed clear on a selected character read
    cs_in = 3'b111; rd_wr = 1; reg_sel = 0;
    latch_stb = 1'b1;
    cyc(2);
    chk("R5 still set before third edge", {7'd0, avail_irq_n}, 8'h00);
    cyc(1);
    chk("R5 cleared after third edge", {7'd0, avail_irq_n}, 8'h01);
    latch_stb = 1'b0; cyc(3);

    // R10: new character meets a clearing edge
    pulse_ready();
    cs_in = 3'b111; rd_wr = 1; reg_sel = 0;
    latch_stb = 1'b1;
    cyc(2);
    rx_ready = 1'b1; cyc(1); rx_ready = 1'b0;
    chk("R10 set wins", {7'd0, avail_irq_n}, 8'h00);
    cyc(2);
    chk("R10 held strobe no re-clear", {7'd0, avail_irq_n}, 8'h00);
    latch_stb = 1'b0; cyc(3);

    // R9: reset clears a set flag
    rst_n = 1'b0; cyc(1);
    chk("R9 reset clears", {7'd0, avail_irq_n}, 8'h01);
    rst_n = 1'b1; cyc(1);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule